// File: doc/BRIEF.md
# Timer Interrupt Flag Logic

This block keeps the pending-interrupt flags for two timer/counters and turns them into interrupt request lines. The timers send it single-cycle event strobes: one wrap strobe per timer, and a compare-match strobe from timer 0. Each timer also sends a counting-direction level. When a timer runs in its up/down (PWM) mode, its overflow flag does not follow the wrap strobe. It is set instead when the counter turns around at zero, which is seen here as the direction level going from down-counting to up-counting.

A flag is cleared in one of two ways. The interrupt controller can send a per-source acknowledge pulse when the CPU enters that source's vector. Software can also write a one to the flag's bit in the status register. A request line is high only while the global enable, the source's own enable and the source's flag are all one. If a set event and a clear arrive in the same cycle, the flag stays set, so no event is lost.

Top module: `tif_timer_flags`

## Requirements
- R1: While `rst_n` is low at a clock edge, all flags go to zero after that edge. While the flags are zero, `irq` is zero.
- R2: In normal mode (`pwm_mode[t]`=0), a high `ovf_stb[t]` sets the overflow flag of timer t. The flag is visible on `rd_data` after the next rising edge.
- R3: In PWM mode (`pwm_mode[t]`=1), the overflow flag of timer t is set on the edge where `cnt_down[t]` is 0 and was 1 at the previous edge (the count turns from down to up at zero). In this mode `ovf_stb[t]` is ignored, and a change from up to down sets nothing.
- R4: In normal mode, changes of `cnt_down[t]` never set a flag.
- R5: A high `cmp0_stb` sets the timer 0 compare flag after the next rising edge.
- R6: A high bit of `ack` clears the matching flag at the next rising edge. Bit positions follow R10.
- R7: When `wr_en` is high, each one in `wr_data[2:0]` clears the matching flag. A zero bit leaves its flag unchanged, and with no event and no clear a flag holds its value.
- R8: A set event in the same cycle as an acknowledge or a write-one leaves the flag at one.
- R9: `irq[i]` = `gie` AND `ien[i]` AND flag i. This is combinational: it follows the current enables and the flag register.
- R10: `rd_data` bit 0 is the timer 0 overflow flag, bit 1 is the timer 0 compare flag and bit 2 is the timer 1 overflow flag. Bits 7:3 always read zero. `ien`, `ack` and `irq` use the same bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovf_stb | input | 2 | Per-timer wrap strobe, bit t = timer t |
| cmp0_stb | input | 1 | Timer 0 compare-match strobe |
| pwm_mode | input | 2 | Per-timer up/down mode select |
| cnt_down | input | 2 | Per-timer direction level, 1 = counting down |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 8 | Write data, ones clear flags |
| rd_data | output | 8 | Status register read value |
| ien | input | 3 | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| ack | input | 3 | Per-source vector acknowledge pulses |
| irq | output | 3 | Per-source interrupt requests |

## Verification
Every set or clear is due on `rd_data` one edge after the cycle it was presented. `irq` follows that flag and the current enables with no further delay. The reversal event needs the direction level from the previous edge, so it also takes effect one edge after the level returns to up. The bench changes inputs on falling edges, lets exactly one rising edge pass, and compares both outputs at the following falling edge before it applies the next vector.

// File: rtl/tif_pkg.sv
// Package: shared sizes and status-bit positions for the timer flag block.
// Assumes two timers, with a compare source on timer 0 only.
package tif_pkg;
    localparam int NUM_TMR = 2;
    localparam int NUM_SRC = 3;
    localparam int REG_W   = 8;
    // Bit positions are software visible; neighbours decode them.
    localparam int IDX_OVF0 = 0;
    localparam int IDX_CMP0 = 1;
    localparam int IDX_OVF1 = 2;
endpackage

// File: rtl/tif_event_detect.sv
// Module: per-timer overflow event source.
// In normal mode the wrap strobe is passed through. In up/down mode an event
// is raised when the direction level changes from down to up, i.e. the count
// turns around at zero. Assumes cnt_down is a level synchronous to clk.
module tif_event_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_stb,
    input  logic pwm_mode,
    input  logic cnt_down,
    output logic set_evt
);
    logic down_q;
    logic reversal;

    // Purpose: remember last direction level for reversal detection.
    always_ff @(posedge clk) begin
        if (!rst_n) down_q <= 1'b0;
        else        down_q <= cnt_down;
    end

    // Purpose: choose the overflow event according to the counting mode.
    always_comb begin
        reversal = down_q & ~cnt_down;
        set_evt  = pwm_mode ? reversal : ovf_stb;
    end

    // R4: normal mode reports only the wrap strobe, never the direction.
    p_normal_dir_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode && !ovf_stb) |-> !set_evt);
    // R3: up/down mode ignores the wrap strobe while still counting down.
    p_pwm_wrap_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && cnt_down) |-> !set_evt);
endmodule

// File: rtl/tif_flag_cell.sv
// Module: one sticky interrupt flag.
// A set event wins over any clear in the same cycle. Assumes set and clr
// are single-cycle qualified pulses.
module tif_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag_q
);
    // Purpose: hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr)     flag_q <= 1'b0;
    end

    // R8: a set event always leaves the flag high.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q);
    // R6: a clear without a set drops the flag.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_evt) |=> !flag_q);
    // R7: with no event and no clear the flag holds.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set_evt) |=> $stable(flag_q));
    // R1: reset empties the flag.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !flag_q);
endmodule

// File: rtl/tif_req_gate.sv
// Module: request gating for all sources.
// Combinational; assumes the flags come straight from registers.
module tif_req_gate #(
    parameter int N = 3
) (
    input  logic         gie,
    input  logic [N-1:0] ien,
    input  logic [N-1:0] flags,
    output logic [N-1:0] irq
);
    // Purpose: request only when global enable, source enable and flag are set.
    always_comb begin
        irq = flags & ien & {N{gie}};
    end
endmodule

// File: rtl/tif_timer_flags.sv
// Module: top of the timer interrupt flag block.
// Maps the event sources onto flag cells, builds the per-source clears from
// acknowledges and write-one-to-clear writes, and gates the requests.
// Assumes all inputs are synchronous to clk.
module tif_timer_flags
    import tif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TMR-1:0]   ovf_stb,
    input  logic                 cmp0_stb,
    input  logic [NUM_TMR-1:0]   pwm_mode,
    input  logic [NUM_TMR-1:0]   cnt_down,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic [NUM_SRC-1:0]   ien,
    input  logic                 gie,
    input  logic [NUM_SRC-1:0]   ack,
    output logic [NUM_SRC-1:0]   irq
);
    logic [NUM_TMR-1:0] ovf_evt;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] flags;

    // One overflow event source per timer.
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        tif_event_detect u_evt (
            .clk      (clk),
            .rst_n    (rst_n),
            .ovf_stb  (ovf_stb[t]),
            .pwm_mode (pwm_mode[t]),
            .cnt_down (cnt_down[t]),
            .set_evt  (ovf_evt[t])
        );
    end

    // Purpose: place events and clears at their status bit positions.
    always_comb begin
        set_vec           = '0;
        set_vec[IDX_OVF0] = ovf_evt[0];
        set_vec[IDX_CMP0] = cmp0_stb;
        set_vec[IDX_OVF1] = ovf_evt[1];
        clr_vec           = ack | (wr_data[NUM_SRC-1:0] & {NUM_SRC{wr_en}});
    end

    // One sticky flag per source.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        tif_flag_cell u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_vec[s]),
            .clr     (clr_vec[s]),
            .flag_q  (flags[s])
        );
    end

    // Purpose: status read value, unused bits zero.
    always_comb begin
        rd_data              = '0;
        rd_data[NUM_SRC-1:0] = flags;
    end

    tif_req_gate #(.N(NUM_SRC)) u_gate (
        .gie   (gie),
        .ien   (ien),
        .flags (flags),
        .irq   (irq)
    );

    // R10: bits above the flags always read zero.
    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:NUM_SRC] == '0);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
        // R9: a request needs both enables and the flag.
        p_req_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
            irq[s] |-> (gie && ien[s] && rd_data[s]));
        // R9: all three set means a request.
        p_req_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (gie && ien[s] && rd_data[s]) |-> irq[s]);
    end
endmodule

// File: tb/tb_tif_timer_flags.sv
// Bench: table of vectors walked by one loop, then directed reset tests.
module tb_tif_timer_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ovf_stb = '0;
    logic       cmp0_stb = 1'b0;
    logic [1:0] pwm_mode = '0;
    logic [1:0] cnt_down = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [2:0] ien = '0;
    logic       gie = 1'b0;
    logic [2:0] ack = '0;
    logic [2:0] irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk; // 50 MHz

    tif_timer_flags dut (
        .clk(clk), .rst_n(rst_n), .ovf_stb(ovf_stb), .cmp0_stb(cmp0_stb),
        .pwm_mode(pwm_mode), .cnt_down(cnt_down), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .ien(ien), .gie(gie),
        .ack(ack), .irq(irq)
    );

    typedef struct packed {
        logic       ovf0, ovf1, cmp0, pwm0, pwm1, dn0, dn1, wr;
        logic [2:0] wd, ak, en;
        logic       g;
        logic [2:0] ef, ei;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    // Flag bits: 0 = timer0 overflow, 1 = timer0 compare, 2 = timer1 overflow.
    localparam vec_t VEC [NV] = '{
        // ovf0 ovf1 cmp0 pwm0 pwm1 dn0 dn1 wr  wd     ack    ien    gie  flags  irq    req
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,3'b000,1'b1,3'b001,3'b000,4'd2}, // R2
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,3'b111,1'b0,3'b101,3'b000,4'd9}, // R9 gie off
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,3'b111,1'b1,3'b111,3'b111,4'd5}, // R5
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'b000,3'b000,3'b010,1'b1,3'b111,3'b010,4'd7}, // R7 zeros
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'b010,3'b000,3'b111,1'b1,3'b101,3'b101,4'd7}, // R7 one
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,3'b001,3'b101,1'b1,3'b100,3'b100,4'd6}, // R6
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,3'b100,3'b000,1'b0,3'b100,3'b000,4'd8}, // R8 ack
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'b100,3'b000,3'b000,1'b0,3'b100,3'b000,4'd8}, // R8 write
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'b111,3'b000,3'b111,1'b1,3'b000,3'b000,4'd7}, // R7 all
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'b000,3'b000,3'b111,1'b1,3'b000,3'b000,4'd4}, // R4 down
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,3'b111,1'b1,3'b000,3'b000,4'd4}, // R4 up
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,3'b000,3'b000,3'b111,1'b1,3'b000,3'b000,4'd3}, // R3 wrap ignored
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,3'b001,1'b1,3'b001,3'b001,4'd3}, // R3 reversal
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,3'b001,3'b000,3'b111,1'b1,3'b000,3'b000,4'd3}, // R3 no repeat
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,3'b000,3'b000,3'b111,1'b1,3'b000,3'b000,4'd3}, // R3 up-to-down
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,3'b000,3'b000,3'b100,1'b1,3'b100,3'b100,4'd3}  // R3 timer1
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below 5000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 flags", rd_data, 8'h00);
        check("R1 irq", {5'd0, irq}, 8'h00);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            ovf_stb  = {VEC[i].ovf1, VEC[i].ovf0};
            cmp0_stb = VEC[i].cmp0;
            pwm_mode = {VEC[i].pwm1, VEC[i].pwm0};
            cnt_down = {VEC[i].dn1, VEC[i].dn0};
            wr_en    = VEC[i].wr;
            wr_data  = {5'b11111, VEC[i].wd};
            ack      = VEC[i].ak;
            ien      = VEC[i].en;
            gie      = VEC[i].g;
            @(negedge clk);
            check($sformatf("R%0d flags vec %0d", VEC[i].req, i), rd_data, {5'd0, VEC[i].ef});
            check($sformatf("R9 irq vec %0d", i), {5'd0, irq}, {5'd0, VEC[i].ei});
        end

        // R10: upper bits stay zero even after a write of ones there.
        check("R10 upper bits", {rd_data[7:3], 3'b000}, 8'h00);

        // R1: reset in mid-run clears pending flags.
        ovf_stb = 2'b11; cmp0_stb = 1'b1; pwm_mode = 2'b00; cnt_down = 2'b00;
        wr_en = 1'b0; ack = '0; ien = 3'b111; gie = 1'b1;
        @(negedge clk);
        ovf_stb = 2'b00; cmp0_stb = 1'b0;
        check("R2 R5 all set", rd_data, 8'h07);
        check("R9 all requests", {5'd0, irq}, 8'h07);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", rd_data, 8'h00);
        check("R1 irq after reset", {5'd0, irq}, 8'h00);
        rst_n = 1'b1;

        // R8: ack and write-one on all bits with all sets at once.
        ovf_stb = 2'b11; cmp0_stb = 1'b1; ack = 3'b111; wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        ovf_stb = 2'b00; cmp0_stb = 1'b0; ack = '0; wr_en = 1'b0;
        check("R8 all sources", rd_data, 8'h07);

        // R6: ack for every source clears everything.
        ack = 3'b111;
        @(negedge clk);
        ack = '0;
        check("R6 ack all", rd_data, 8'h00);

        finish_run();
    end
endmodule